// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 interface. After reset it drives the memory's command pins through the power-up and mode-programming sequence, then hands the bus over to normal traffic. The outputs are the clock enable, the four active-low command strobes, the bank and address buses, and on-die termination. It keeps CKE low through the long power-up window and raises it. It then issues the precharges, the extended and main mode register writes, the refreshes and the off-chip-driver default/exit pair. Every gap between commands is filled with NOPs.

All waits are counted in controller clock cycles. The power-up and CKE settle times are given in nanoseconds and converted with a clock-period parameter. Precharge, refresh and register-write spacings and the DLL lock window are given directly as cycle counts. One down-counter times every wait. The mode register contents come from four static configuration inputs: burst length, burst ordering, CAS latency and write recovery. When the sequence is complete, `init_done` pulses for one cycle and `ready` stays high until the next reset.

Top module: `ddr2i_init_seq`

## Requirements
- R1: From reset, `cke` is low and the command is NOP. `cke` rises exactly ceil(T_POWERUP_NS*1000/CLK_PS) cycles after reset is released, stays high from then on, and no command other than NOP appears while it is low.
- R2: The first precharge-all is issued exactly ceil(T_CKE_NS*1000/CLK_PS) cycles after `cke` rises. A precharge-all is encoded {cs_n,ras_n,cas_n,we_n} = 0010 with addr[10] high.
- R3: After reset, exactly these non-NOP commands appear, in this order: precharge-all, EMR2 write, EMR3 write, EMR1 write, MR write with DLL reset, precharge-all, N_REF refreshes, MR write without DLL reset, EMR1 OCD default, EMR1 OCD exit.
- R4: A register write is encoded {cs_n,ras_n,cas_n,we_n} = 0000, with ba selecting the register: 0 = MR, 1 = EMR1, 2 = EMR2, 3 = EMR3. The EMR2, EMR3 and DLL-enable EMR1 writes carry an all-zero address.
- R5: Each MR write carries the following address fields. addr[2:0] is 010 for burst 4 (cfg_bl8 = 0) or 011 for burst 8. addr[3] is cfg_interleave. addr[6:4] is cfg_cas_lat. addr[7] is 0. addr[8] is 1 on the first MR write and 0 on the second. addr[11:9] is cfg_wr_rec. All higher bits are 0.
- R6: Each command is one cycle wide, and commands are spaced as follows: T_RP after a precharge, T_RFC after a refresh, and T_MRD after a register write. NOP is encoded 0111.
- R7: A refresh is encoded 0001. The number of refreshes issued equals N_REF, which must be at least 2.
- R8: The OCD default write goes to EMR1 with addr = 0x380 (bits 9:7 high). It is issued max(T_MRD, DLL_LOCK_CYC - (T_MRD + T_RP + N_REF*T_RFC)) cycles after the second MR write, which places it at least DLL_LOCK_CYC cycles after the DLL-reset write. The OCD exit write (EMR1, addr 0) follows T_MRD cycles later.
- R9: `init_done` is high for exactly one cycle, T_MRD cycles after the OCD exit write. `ready` rises in that same cycle.
- R10: Once `ready` is high, `restart_req` has no effect: commands stay NOP, `ready` stays high and `init_done` stays low until reset.
- R11: `odt` is low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bl8 | input | 1 | 1 selects burst length 8, 0 selects 4 |
| cfg_interleave | input | 1 | Burst ordering bit for the mode register |
| cfg_cas_lat | input | 3 | CAS latency code |
| cfg_wr_rec | input | 3 | Write recovery code |
| restart_req | input | 1 | Restart request, ignored once ready |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address / register select |
| addr | output | ROW_W | Address bus |
| odt | output | 1 | On-die termination, held low |
| init_done | output | 1 | One-cycle completion pulse |
| ready | output | 1 | Level: sequence complete |

## Verification
The hardest case to reach is the DLL lock window. It is only visible when the wait between the second MR write and the OCD default is stretched beyond T_MRD, and when it is not. The bench therefore builds two instances side by side. In one, the refresh and precharge spacings are short against the lock window, so the stretched gap is in force. In the other, the lock window is shorter than those spacings, so the gap collapses to T_MRD. Every one of the 64 CAS-latency and write-recovery pairs, each with its own burst settings, is run through a full reset-to-ready sequence. The cycle of every command is compared with offsets summed arithmetically from each instance's parameters.

// File: rtl/ddr2i_pkg.sv
package ddr2i_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } ddr2i_cmd_e;

   typedef enum logic [3:0] {
      ST_POWER,
      ST_CKE,
      ST_PRE1,
      ST_EMR2,
      ST_EMR3,
      ST_EMR1,
      ST_MR_RST,
      ST_PRE2,
      ST_REF,
      ST_MR_OP,
      ST_OCD_DEF,
      ST_OCD_EXIT,
      ST_DONE
   } ddr2i_step_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ddr2i_wait_timer.sv
module ddr2i_wait_timer #(
   parameter int CNT_W     = 16,
   parameter int RESET_VAL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   initial begin
      assert (RESET_VAL >= 0 && RESET_VAL < (2 ** CNT_W))
         else $error("ddr2i_wait_timer: RESET_VAL does not fit CNT_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_W'(RESET_VAL);
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   // R6
   load_only_when_expired_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> expired);

endmodule

// File: rtl/ddr2i_step_ctrl.sv
module ddr2i_step_ctrl
   import ddr2i_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int CKE_CYC = 100,
   parameter int T_RP    = 4,
   parameter int T_RFC   = 32,
   parameter int T_MRD   = 2,
   parameter int OCD_GAP = 2,
   parameter int N_REF   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             expired,
   output ddr2i_step_e      step_q,
   output ddr2i_step_e      nxt_step,
   output logic             advance,
   output logic [CNT_W-1:0] load_val
);

   localparam int REF_W = $clog2(N_REF + 1);

   logic [REF_W-1:0] ref_cnt_q;

   initial begin
      assert (N_REF >= 2) else $error("ddr2i_step_ctrl: N_REF below 2");
      assert (T_MRD >= 2 && T_RP >= 2 && T_RFC >= 2 && CKE_CYC >= 2)
         else $error("ddr2i_step_ctrl: spacings must be at least 2 cycles");
   end

   assign advance = expired && (step_q != ST_DONE);

   always_comb begin
      case (step_q)
         ST_POWER:    nxt_step = ST_CKE;
         ST_CKE:      nxt_step = ST_PRE1;
         ST_PRE1:     nxt_step = ST_EMR2;
         ST_EMR2:     nxt_step = ST_EMR3;
         ST_EMR3:     nxt_step = ST_EMR1;
         ST_EMR1:     nxt_step = ST_MR_RST;
         ST_MR_RST:   nxt_step = ST_PRE2;
         ST_PRE2:     nxt_step = ST_REF;
         ST_REF:      nxt_step = (ref_cnt_q == REF_W'(N_REF)) ? ST_MR_OP : ST_REF;
         ST_MR_OP:    nxt_step = ST_OCD_DEF;
         ST_OCD_DEF:  nxt_step = ST_OCD_EXIT;
         ST_OCD_EXIT: nxt_step = ST_DONE;
         default:     nxt_step = ST_DONE;
      endcase
   end

   always_comb begin
      case (nxt_step)
         ST_CKE:              load_val = CNT_W'(CKE_CYC - 1);
         ST_PRE1, ST_PRE2:    load_val = CNT_W'(T_RP - 1);
         ST_REF:              load_val = CNT_W'(T_RFC - 1);
         ST_MR_OP:            load_val = CNT_W'(OCD_GAP - 1);
         ST_EMR2, ST_EMR3, ST_EMR1, ST_MR_RST,
         ST_OCD_DEF, ST_OCD_EXIT:
                              load_val = CNT_W'(T_MRD - 1);
         default:             load_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q    <= ST_POWER;
         ref_cnt_q <= '0;
      end else if (advance) begin
         step_q <= nxt_step;
         if (nxt_step == ST_REF) begin
            ref_cnt_q <= ref_cnt_q + 1'b1;
         end
      end
   end

   // R7
   ref_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_cnt_q <= REF_W'(N_REF));

   // R10
   done_is_terminal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == ST_DONE) |=> (step_q == ST_DONE));

endmodule

// File: rtl/ddr2i_mode_word.sv
module ddr2i_mode_word
   import ddr2i_pkg::*;
#(
   parameter int ROW_W  = 14,
   parameter int BANK_W = 2
) (
   input  ddr2i_step_e       step,
   input  logic              cfg_bl8,
   input  logic              cfg_interleave,
   input  logic [2:0]        cfg_cas_lat,
   input  logic [2:0]        cfg_wr_rec,
   output ddr2i_cmd_e        cmd,
   output logic [BANK_W-1:0] ba,
   output logic [ROW_W-1:0]  addr
);

   localparam int WORD_W = 14;

   logic [WORD_W-1:0] word;
   logic [WORD_W-1:0] mr_base;

   initial begin
      assert (ROW_W >= 13) else $error("ddr2i_mode_word: ROW_W below 13");
      assert (BANK_W >= 2) else $error("ddr2i_mode_word: BANK_W below 2");
   end

   // [11:9] write recovery, [8] DLL reset (added per step), [7] test = 0,
   // [6:4] CAS latency, [3] ordering, [2:0] burst code 010 / 011
   assign mr_base = {2'b00, cfg_wr_rec, 1'b0, 1'b0, cfg_cas_lat,
                     cfg_interleave, 1'b0, 1'b1, cfg_bl8};

   always_comb begin
      cmd  = CMD_NOP;
      ba   = '0;
      word = '0;
      case (step)
         ST_PRE1, ST_PRE2: begin
            cmd      = CMD_PRE;
            word[10] = 1'b1;
         end
         ST_EMR2: begin
            cmd = CMD_MRS;
            ba  = BANK_W'(2);
         end
         ST_EMR3: begin
            cmd = CMD_MRS;
            ba  = BANK_W'(3);
         end
         ST_EMR1, ST_OCD_EXIT: begin
            cmd = CMD_MRS;
            ba  = BANK_W'(1);
         end
         ST_OCD_DEF: begin
            cmd       = CMD_MRS;
            ba        = BANK_W'(1);
            word[9:7] = 3'b111;
         end
         ST_MR_RST: begin
            cmd     = CMD_MRS;
            word    = mr_base;
            word[8] = 1'b1;
         end
         ST_MR_OP: begin
            cmd  = CMD_MRS;
            word = mr_base;
         end
         ST_REF: begin
            cmd = CMD_REF;
         end
         default: begin
            cmd = CMD_NOP;
         end
      endcase
   end

   generate
      if (ROW_W > WORD_W) begin : g_wide
         assign addr = {{(ROW_W - WORD_W){1'b0}}, word};
      end else begin : g_narrow
         logic unused_hi;
         assign addr      = word[ROW_W-1:0];
         assign unused_hi = ^word;
      end
   endgenerate

endmodule

// File: rtl/ddr2i_init_seq.sv
module ddr2i_init_seq
   import ddr2i_pkg::*;
#(
   parameter int CLK_PS       = 4000,
   parameter int T_POWERUP_NS = 200000,
   parameter int T_CKE_NS     = 400,
   parameter int T_RP         = 4,
   parameter int T_RFC        = 32,
   parameter int T_MRD        = 2,
   parameter int DLL_LOCK_CYC = 200,
   parameter int N_REF        = 2,
   parameter int ROW_W        = 14,
   parameter int BANK_W       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_bl8,
   input  logic              cfg_interleave,
   input  logic [2:0]        cfg_cas_lat,
   input  logic [2:0]        cfg_wr_rec,
   input  logic              restart_req,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BANK_W-1:0] ba,
   output logic [ROW_W-1:0]  addr,
   output logic              odt,
   output logic              init_done,
   output logic              ready
);

   localparam int POWERUP_CYC = ceil_div(T_POWERUP_NS * 1000, CLK_PS);
   localparam int CKE_CYC     = ceil_div(T_CKE_NS * 1000, CLK_PS);
   localparam int PRE_OCD     = T_MRD + T_RP + N_REF * T_RFC;
   localparam int OCD_GAP     = (DLL_LOCK_CYC > PRE_OCD + T_MRD) ?
                                (DLL_LOCK_CYC - PRE_OCD) : T_MRD;
   localparam int MAX_WAIT    = max2(max2(max2(POWERUP_CYC, CKE_CYC), max2(T_RP, T_RFC)),
                                     max2(OCD_GAP, T_MRD));
   localparam int CNT_W       = $clog2(MAX_WAIT + 1);

   initial begin
      assert (CLK_PS > 0) else $error("ddr2i_init_seq: CLK_PS must be positive");
      assert (POWERUP_CYC >= 2) else $error("ddr2i_init_seq: power-up window too short");
   end

   ddr2i_step_e       step_q;
   ddr2i_step_e       nxt_step;
   logic              advance;
   logic              expired;
   logic [CNT_W-1:0]  load_val;
   ddr2i_cmd_e        mw_cmd;
   logic [BANK_W-1:0] mw_ba;
   logic [ROW_W-1:0]  mw_addr;
   ddr2i_cmd_e        cmd_q;

   ddr2i_wait_timer #(
      .CNT_W     (CNT_W),
      .RESET_VAL (POWERUP_CYC - 1)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (advance),
      .load_val (load_val),
      .expired  (expired)
   );

   ddr2i_step_ctrl #(
      .CNT_W   (CNT_W),
      .CKE_CYC (CKE_CYC),
      .T_RP    (T_RP),
      .T_RFC   (T_RFC),
      .T_MRD   (T_MRD),
      .OCD_GAP (OCD_GAP),
      .N_REF   (N_REF)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .expired  (expired),
      .step_q   (step_q),
      .nxt_step (nxt_step),
      .advance  (advance),
      .load_val (load_val)
   );

   ddr2i_mode_word #(
      .ROW_W  (ROW_W),
      .BANK_W (BANK_W)
   ) u_word (
      .step           (nxt_step),
      .cfg_bl8        (cfg_bl8),
      .cfg_interleave (cfg_interleave),
      .cfg_cas_lat    (cfg_cas_lat),
      .cfg_wr_rec     (cfg_wr_rec),
      .cmd            (mw_cmd),
      .ba             (mw_ba),
      .addr           (mw_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cke       <= 1'b0;
         cmd_q     <= CMD_NOP;
         ba        <= '0;
         addr      <= '0;
         init_done <= 1'b0;
         ready     <= 1'b0;
      end else begin
         init_done <= 1'b0;
         cmd_q     <= CMD_NOP;
         if (advance) begin
            cmd_q <= mw_cmd;
            ba    <= mw_ba;
            addr  <= mw_addr;
            if (nxt_step == ST_CKE) begin
               cke <= 1'b1;
            end
            if (nxt_step == ST_DONE) begin
               init_done <= 1'b1;
               ready     <= 1'b1;
            end
         end
      end
   end

   assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
   assign odt = 1'b0;

   // R1
   cke_stays_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> cke);

   // R1
   nop_while_cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

   // R2
   precharge_all_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({cs_n, ras_n, cas_n, we_n} == 4'b0010) |-> addr[10]);

   // R6
   single_cycle_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({cs_n, ras_n, cas_n, we_n} != 4'b0111) |=> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> (!init_done && ready));

   // R10
   restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && restart_req) |=> (ready && !init_done && cs_n == 1'b0 && ras_n && cas_n && we_n));

endmodule

// File: tb/tb_ddr2i_init_seq.sv
`timescale 1ns/1ps
module tb_ddr2i_init_seq;

   localparam int CLK_PS  = 4000;
   localparam int PWR_NS  = 400;
   localparam int PWR_CYC = 100;
   localparam int CKE_CYC = 100;
   localparam int MAXEV   = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_bl8 = 1'b0;
   logic cfg_interleave = 1'b0;
   logic [2:0] cfg_cas_lat = 3'd0;
   logic [2:0] cfg_wr_rec = 3'd0;
   logic restart_req = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   logic        a_cke, a_cs, a_ras, a_cas, a_we, a_odt, a_done, a_rdy;
   logic [1:0]  a_ba;
   logic [13:0] a_addr;
   logic        b_cke, b_cs, b_ras, b_cas, b_we, b_odt, b_done, b_rdy;
   logic [1:0]  b_ba;
   logic [13:0] b_addr;

   // Instance with a long lock window: stretched gap before OCD default
   ddr2i_init_seq #(
      .CLK_PS (CLK_PS), .T_POWERUP_NS (PWR_NS), .T_CKE_NS (400),
      .T_RP (3), .T_RFC (10), .T_MRD (2), .DLL_LOCK_CYC (200), .N_REF (2),
      .ROW_W (14), .BANK_W (2)
   ) dut (
      .clk (clk), .rst_n (rst_n), .cfg_bl8 (cfg_bl8), .cfg_interleave (cfg_interleave),
      .cfg_cas_lat (cfg_cas_lat), .cfg_wr_rec (cfg_wr_rec), .restart_req (restart_req),
      .cke (a_cke), .cs_n (a_cs), .ras_n (a_ras), .cas_n (a_cas), .we_n (a_we),
      .ba (a_ba), .addr (a_addr), .odt (a_odt), .init_done (a_done), .ready (a_rdy)
   );

   // Instance with a short lock window: gap collapses to T_MRD
   ddr2i_init_seq #(
      .CLK_PS (CLK_PS), .T_POWERUP_NS (PWR_NS), .T_CKE_NS (400),
      .T_RP (4), .T_RFC (12), .T_MRD (3), .DLL_LOCK_CYC (10), .N_REF (3),
      .ROW_W (14), .BANK_W (2)
   ) dut_b (
      .clk (clk), .rst_n (rst_n), .cfg_bl8 (cfg_bl8), .cfg_interleave (cfg_interleave),
      .cfg_cas_lat (cfg_cas_lat), .cfg_wr_rec (cfg_wr_rec), .restart_req (restart_req),
      .cke (b_cke), .cs_n (b_cs), .ras_n (b_ras), .cas_n (b_cas), .we_n (b_we),
      .ba (b_ba), .addr (b_addr), .odt (b_odt), .init_done (b_done), .ready (b_rdy)
   );

   // {cke, cmd[3:0], ba[1:0], addr[13:0], odt, done, ready}
   logic [23:0] obs [2];
   assign obs[0] = {a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_odt, a_done, a_rdy};
   assign obs[1] = {b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_odt, b_done, b_rdy};

   function automatic int p_rp(input int k);   return (k == 0) ? 3 : 4;    endfunction
   function automatic int p_rfc(input int k);  return (k == 0) ? 10 : 12;  endfunction
   function automatic int p_mrd(input int k);  return (k == 0) ? 2 : 3;    endfunction
   function automatic int p_lock(input int k); return (k == 0) ? 200 : 10; endfunction
   function automatic int p_nref(input int k); return (k == 0) ? 2 : 3;    endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // logged events per instance
   int ev_n   [2];
   int ev_cyc [2][MAXEV];
   int ev_cmd [2][MAXEV];
   int ev_ba  [2][MAXEV];
   int ev_adr [2][MAXEV];
   int cke_rise [2];
   int done_cyc [2];
   int done_cnt [2];
   int bad_low  [2];
   int odt_hi   [2];

   task automatic run_one(input int cl, input int wr, input bit bt, input bit bl8);
      int mr_word;
      bit fin;
      cfg_cas_lat    = 3'(cl);
      cfg_wr_rec     = 3'(wr);
      cfg_interleave = bt;
      cfg_bl8        = bl8;
      restart_req    = 1'b0;
      rst_n          = 1'b0;
      repeat (3) @(negedge clk);
      for (int k = 0; k < 2; k++) begin
         // R1 reset state: cke low, NOP, not ready, no pulse
         check(obs[k][23] == 1'b0, "R1 reset cke", int'(obs[k][23]), 0);
         check(obs[k][22:19] == 4'b0111, "R1 reset NOP", int'(obs[k][22:19]), 7);
         check(obs[k][1:0] == 2'b00, "R9 reset done/ready", int'(obs[k][1:0]), 0);
         ev_n[k] = 0; cke_rise[k] = -1; done_cyc[k] = -1; done_cnt[k] = 0;
         bad_low[k] = 0; odt_hi[k] = 0;
      end
      rst_n = 1'b1;
      fin = 1'b0;
      for (int cyc = 1; cyc <= 1500 && !fin; cyc++) begin
         @(negedge clk);
         for (int k = 0; k < 2; k++) begin
            if (obs[k][23] && cke_rise[k] < 0) cke_rise[k] = cyc;
            if (obs[k][2]) odt_hi[k]++;
            if (obs[k][22:19] != 4'b0111) begin
               if (!obs[k][23]) bad_low[k]++;
               if (ev_n[k] < MAXEV) begin
                  ev_cyc[k][ev_n[k]] = cyc;
                  ev_cmd[k][ev_n[k]] = int'(obs[k][22:19]);
                  ev_ba[k][ev_n[k]]  = int'(obs[k][18:17]);
                  ev_adr[k][ev_n[k]] = int'(obs[k][16:3]);
               end
               ev_n[k]++;
            end
            if (obs[k][1]) begin
               done_cnt[k]++;
               done_cyc[k] = cyc;
            end
         end
         if (obs[0][0] && obs[1][0]) fin = 1'b1;
      end

      mr_word = (wr << 9) | (cl << 4) | (int'(bt) << 3) | (bl8 ? 3 : 2);

      for (int k = 0; k < 2; k++) begin
         int rp, rfc, mrd, lock, nref, t, mr_t, pre, gap, i, nexp;
         int ecyc [MAXEV];
         int ecmd [MAXEV];
         int eba  [MAXEV];
         int eadr [MAXEV];
         int emsk [MAXEV];
         rp = p_rp(k); rfc = p_rfc(k); mrd = p_mrd(k); lock = p_lock(k); nref = p_nref(k);
         i = 0; t = CKE_CYC;
         ecyc[i] = t; ecmd[i] = 2; eba[i] = 0; eadr[i] = 1 << 10; emsk[i] = 1 << 10; i++; t += rp;
         ecyc[i] = t; ecmd[i] = 0; eba[i] = 2; eadr[i] = 0; emsk[i] = 16'h3fff; i++; t += mrd;
         ecyc[i] = t; ecmd[i] = 0; eba[i] = 3; eadr[i] = 0; emsk[i] = 16'h3fff; i++; t += mrd;
         ecyc[i] = t; ecmd[i] = 0; eba[i] = 1; eadr[i] = 0; emsk[i] = 16'h3fff; i++; t += mrd;
         mr_t = t;
         ecyc[i] = t; ecmd[i] = 0; eba[i] = 0; eadr[i] = mr_word | (1 << 8); emsk[i] = 16'h3fff; i++; t += mrd;
         ecyc[i] = t; ecmd[i] = 2; eba[i] = 0; eadr[i] = 1 << 10; emsk[i] = 1 << 10; i++; t += rp;
         for (int r = 0; r < nref; r++) begin
            ecyc[i] = t; ecmd[i] = 1; eba[i] = 0; eadr[i] = 0; emsk[i] = 0; i++; t += rfc;
         end
         ecyc[i] = t; ecmd[i] = 0; eba[i] = 0; eadr[i] = mr_word; emsk[i] = 16'h3fff; i++;
         pre = t + mrd - mr_t;
         gap = (lock - (t - mr_t) > mrd) ? lock - (t - mr_t) : mrd;
         pre = pre + 0;
         t += gap;
         ecyc[i] = t; ecmd[i] = 0; eba[i] = 1; eadr[i] = 16'h380; emsk[i] = 16'h3fff; i++; t += mrd;
         ecyc[i] = t; ecmd[i] = 0; eba[i] = 1; eadr[i] = 0; emsk[i] = 16'h3fff; i++; t += mrd;
         nexp = i;

         // R1 power-up window length and no command while cke low
         check(cke_rise[k] == PWR_CYC, "R1 cke rise cycle", cke_rise[k], PWR_CYC);
         check(bad_low[k] == 0, "R1 command while cke low", bad_low[k], 0);
         // R11 odt never high
         check(odt_hi[k] == 0, "R11 odt high cycles", odt_hi[k], 0);
         // R3 R7 count of non-NOP commands
         check(ev_n[k] == nexp, "R3 R7 command count", ev_n[k], nexp);
         for (int e = 0; e < nexp && e < ev_n[k] && e < MAXEV; e++) begin
            // R2 R6 R8 timing relative to cke rise
            check(ev_cyc[k][e] - cke_rise[k] == ecyc[e], "R2 R6 R8 command cycle",
                  ev_cyc[k][e] - cke_rise[k], ecyc[e]);
            // R3 R4 R7 command code
            check(ev_cmd[k][e] == ecmd[e], "R3 R4 R7 command code", ev_cmd[k][e], ecmd[e]);
            if (ecmd[e] == 0) begin
               // R4 register select
               check(ev_ba[k][e] == eba[e], "R4 register select", ev_ba[k][e], eba[e]);
            end
            // R4 R5 R8 address contents
            check((ev_adr[k][e] & emsk[e]) == eadr[e], "R4 R5 R8 address",
                  ev_adr[k][e] & emsk[e], eadr[e]);
         end
         if (ev_n[k] >= nexp) begin
            // R8 DLL lock window honoured
            check(ev_cyc[k][nexp-2] - ev_cyc[k][4] >= lock, "R8 lock window",
                  ev_cyc[k][nexp-2] - ev_cyc[k][4], lock);
         end
         // R9 completion pulse timing and width
         check(done_cyc[k] - cke_rise[k] == t, "R9 done cycle", done_cyc[k] - cke_rise[k], t);
         check(done_cnt[k] == 1, "R9 done pulse count", done_cnt[k], 1);
      end

      // R10 restart request after ready has no effect
      restart_req = 1'b1;
      repeat (3) @(negedge clk);
      restart_req = 1'b0;
      for (int k = 0; k < 2; k++) bad_low[k] = 0;
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         for (int k = 0; k < 2; k++) begin
            if (obs[k][22:19] != 4'b0111 || !obs[k][0] || obs[k][1] || !obs[k][23])
               bad_low[k]++;
         end
      end
      for (int k = 0; k < 2; k++)
         check(bad_low[k] == 0, "R10 restart ignored", bad_low[k], 0);
   endtask

   initial begin
      #(4 * 190000);
      n_tests++;
      n_fail++;
      $display("FAIL R9 watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int cl = 0; cl < 8; cl++) begin
         for (int wr = 0; wr < 8; wr++) begin
            run_one(cl, wr, bit'((cl + wr) & 1), bit'(((cl >> 1) ^ wr) & 1));
         end
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule